// File: doc/BRIEF.md
# Overflow-Triggered Trace Sampling Engine

A per-thread sampler that needs no interrupt. Software loads two 64-bit setup words. The base word holds an enable bit, a mode bit and an 8 KiB-aligned memory base. The trace word holds a 32-bit period preload, two event selects and a buffer size code. A 32-bit sampling counter starts at the preload and counts processor cycles. When the counter passes all-ones, the engine snapshots the program counter, two event tallies and a free-running timestamp, then reloads the counter by itself.

In trace mode each snapshot goes out as a 32-byte record of four 64-bit beats on a valid/ready write port. The record lands at the base plus a running offset, and that offset wraps silently inside a circular buffer. In accumulation mode each overflow instead emits two "add" beats, which fold the event tallies into two fixed words at the base. The memory fabric is abstracted as that single write port.

Top module: `trace_sampler`

## Requirements
- R1: While reset is held, and after it until the unit is enabled, no write beat is issued. The write offset starts at zero.
- R2: Base word fields, numbered with bit 63 as the most significant: bit 63 enables the unit. Bit 62 selects the mode (1 = trace, 0 = accumulate). Bits 55:13 give address bits 55:13 of the base, and address bits 12:0 are zero. All other bits have no effect.
- R3: Trace word fields: bits 61:30 are the period preload L, bits 29:23 select event A, bits 22:16 select event B, and bits 15:13 are the size code. All other bits have no effect.
- R4: The sampling counter advances once per active cycle. A cycle is active when the unit is enabled, no record is outstanding and no setup word is being written. The counter reaches overflow on the (2^32 − L)-th active cycle after a reload, so L = all-ones samples on every active cycle. The program counter is taken in the overflow cycle.
- R5: A trace record is four beats with the add flag low. The beats go to A, A+8, A+16 and A+24, where A is base + offset. They carry, in that order, the program counter, tally A, tally B and the timestamp. The first beat is offered in the cycle after the overflow.
- R6: Each tally counts the active cycles of the period, including the overflow cycle, in which the input bit picked by its select is high. A select at or above the number of event inputs counts nothing. Both tallies restart from zero after each sample.
- R7: The timestamp is a free-running cycle counter. Consecutive records differ by exactly the number of clock cycles between their overflow cycles.
- R8: After every trace record the offset grows by 32 bytes. It wraps to zero modulo 4096 << code, with no other signal raised.
- R9: In accumulation mode an overflow emits two beats with the add flag high: tally A at the base and tally B at base+8.
- R10: A beat that is not accepted holds its address, data and flag until it is. No counter advances while a record is outstanding, so no sample is lost, and the next overflow comes later by exactly the stall.
- R11: Writing either setup word while enabled resets the offset to zero, reloads the sampling counter from the new preload and clears both tallies.
- R12: While the enable bit is clear, no new record starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_base | input | 1 | Write strobe for the base word |
| cfg_wr_trace | input | 1 | Write strobe for the trace word |
| cfg_wdata | input | 64 | Setup write data |
| pc_in | input | PC_W | Current program counter |
| ev_in | input | NUM_EV | Event pulse inputs, one per source |
| mem_valid | output | 1 | Write beat offered |
| mem_ready | input | 1 | Write beat accepted |
| mem_addr | output | 56 | Byte address of the beat |
| mem_data | output | 64 | Beat data |
| mem_add | output | 1 | 1 = add data into memory, 0 = store |

## Verification
Every cycle, the checker enforces these port-level rules:
- A stalled beat stays frozen.
- The sampling counter stays still while a record is outstanding.
- A disabled, idle engine stays idle.
- Beats are 8-byte aligned, and every record starts on a 32-byte boundary in the cycle after an overflow.
- The port goes quiet after the last beat.
- Accumulation beats never leave the two words at the base.

The bench's scenarios are the only way to show the following:
- The program counter and both tallies are taken in the right overflow cycle for every period and select.
- Timestamps are spaced by the true cycle distance.
- The offset wraps at each buffer size.
- A reconfiguration restarts the buffer.

// File: rtl/ts_pkg.sv
package ts_pkg;
   localparam int REG_W     = 64;
   localparam int LOAD_W    = 32;
   localparam int SEL_W     = 7;
   localparam int CODE_W    = 3;
   localparam int ADDR_W    = 56;
   localparam int BEAT_W    = 64;
   localparam int REC_BEATS = 4;
   localparam int REC_BYTES = 32;
   localparam int OFF_W     = 12 + (1 << CODE_W) - 1;
   localparam int EV_PAD    = 1 << SEL_W;

   // field positions, bit 63 most significant
   localparam int F_EN      = 63;
   localparam int F_TRACE   = 62;
   localparam int F_BASE_HI = 55;
   localparam int F_BASE_LO = 13;
   localparam int F_LOAD_HI = 61;
   localparam int F_LOAD_LO = 30;
   localparam int F_SA_HI   = 29;
   localparam int F_SA_LO   = 23;
   localparam int F_SB_HI   = 22;
   localparam int F_SB_LO   = 16;
   localparam int F_CODE_HI = 15;
   localparam int F_CODE_LO = 13;

   typedef struct packed {
      logic              en;
      logic              trace;
      logic [ADDR_W-1:0] base;
   } base_cfg_t;

   typedef struct packed {
      logic [LOAD_W-1:0] load;
      logic [SEL_W-1:0]  sel_a;
      logic [SEL_W-1:0]  sel_b;
      logic [CODE_W-1:0] code;
   } trc_cfg_t;
endpackage

// File: rtl/ts_cfg_regs.sv
module ts_cfg_regs
   import ts_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_base,
   input  logic              wr_trc,
   input  logic [REG_W-1:0]  wdata,
   output base_cfg_t         base_q,
   output trc_cfg_t          trc_q,
   output logic [LOAD_W-1:0] load_nxt,
   output logic              touch,
   output logic              clr_off
);
   logic unused_low_bits;
   assign unused_low_bits = ^wdata[F_BASE_LO-1:0];

   base_cfg_t base_d;
   trc_cfg_t  trc_d;

   always_comb begin
      base_d.en    = wdata[F_EN];
      base_d.trace = wdata[F_TRACE];
      base_d.base  = {wdata[F_BASE_HI:F_BASE_LO], {F_BASE_LO{1'b0}}};
      trc_d.load   = wdata[F_LOAD_HI:F_LOAD_LO];
      trc_d.sel_a  = wdata[F_SA_HI:F_SA_LO];
      trc_d.sel_b  = wdata[F_SB_HI:F_SB_LO];
      trc_d.code   = wdata[F_CODE_HI:F_CODE_LO];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         trc_q  <= '0;
      end else begin
         if (wr_base) base_q <= base_d;
         if (wr_trc)  trc_q  <= trc_d;
      end
   end

   assign touch    = wr_base | wr_trc;
   assign clr_off  = touch & base_q.en;
   assign load_nxt = wr_trc ? trc_d.load : trc_q.load;
endmodule

// File: rtl/ts_sample_ctr.sv
module ts_sample_ctr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reload,
   input  logic         step,
   input  logic [W-1:0] load,
   output logic         fire,
   output logic [W-1:0] cnt_q
);
   assign fire = step && (cnt_q == {W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (reload || fire) cnt_q <= load;
      else if (step)           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/ts_event_ctr.sv
module ts_event_ctr #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic         ev,
   output logic [W-1:0] snap
);
   logic [W-1:0] cnt_q;
   logic         hit;

   assign hit  = step & ev;
   assign snap = cnt_q + W'(hit);

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (hit) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/ts_record_emit.sv
module ts_record_emit
   import ts_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              trace_in,
   input  logic [ADDR_W-1:0] base,
   input  logic [CODE_W-1:0] code,
   input  logic              off_clr,
   input  logic [BEAT_W-1:0] pc_w,
   input  logic [BEAT_W-1:0] cnt_a,
   input  logic [BEAT_W-1:0] cnt_b,
   input  logic [BEAT_W-1:0] ts_w,
   input  logic              mem_ready,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BEAT_W-1:0] mem_data,
   output logic              mem_add,
   output logic              beat_last
);
   localparam int IDX_W = $clog2(REC_BEATS);
   localparam int SZ_W  = OFF_W + 1;

   logic              busy_q, mode_q;
   logic [IDX_W-1:0]  beat_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BEAT_W-1:0] rec_q [REC_BEATS];
   logic [OFF_W-1:0]  off_q, off_nxt;
   logic [SZ_W-1:0]   size_b, off_sum;
   logic [BEAT_W-1:0] cap [REC_BEATS];

   assign size_b  = SZ_W'(4096) << code;
   assign off_sum = (SZ_W'(off_q) + SZ_W'(REC_BYTES)) & (size_b - SZ_W'(1));
   assign off_nxt = off_sum[OFF_W-1:0];

   // beat order depends on the mode: a record or two add words
   always_comb begin
      if (trace_in) begin
         cap[0] = pc_w;  cap[1] = cnt_a; cap[2] = cnt_b; cap[3] = ts_w;
      end else begin
         cap[0] = cnt_a; cap[1] = cnt_b; cap[2] = '0;    cap[3] = '0;
      end
   end

   assign beat_last = (beat_q == (mode_q ? IDX_W'(REC_BEATS - 1) : IDX_W'(1)));
   assign mem_valid = busy_q;
   assign mem_addr  = addr_q + ADDR_W'({beat_q, 3'b000});
   assign mem_data  = rec_q[beat_q];
   assign mem_add   = ~mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         mode_q <= 1'b1;
         beat_q <= '0;
         addr_q <= '0;
         for (int i = 0; i < REC_BEATS; i++) rec_q[i] <= '0;
      end else if (fire) begin
         busy_q <= 1'b1;
         mode_q <= trace_in;
         beat_q <= '0;
         addr_q <= trace_in ? base + ADDR_W'(off_q) : base;
         for (int i = 0; i < REC_BEATS; i++) rec_q[i] <= cap[i];
      end else if (busy_q && mem_ready) begin
         if (beat_last) busy_q <= 1'b0;
         beat_q <= beat_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                off_q <= '0;
      else if (off_clr)          off_q <= '0;
      else if (fire && trace_in) off_q <= off_nxt;
   end
endmodule

// File: rtl/trace_sampler.sv
module trace_sampler
   import ts_pkg::*;
#(
   parameter int NUM_EV   = 8,
   parameter int EV_W     = 64,
   parameter int TS_W     = 64,
   parameter int PC_W     = 64,
   parameter bit ACCUM_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_base,
   input  logic              cfg_wr_trace,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [NUM_EV-1:0] ev_in,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BEAT_W-1:0] mem_data,
   output logic              mem_add
);
   localparam int N_TALLY = 2;

   if (NUM_EV < 1 || NUM_EV > EV_PAD) begin : g_bad_nev
      $error("trace_sampler: NUM_EV must lie in 1..128");
   end
   if (EV_W < 1 || EV_W > BEAT_W) begin : g_bad_evw
      $error("trace_sampler: EV_W must lie in 1..64");
   end
   if (TS_W < 1 || TS_W > BEAT_W) begin : g_bad_tsw
      $error("trace_sampler: TS_W must lie in 1..64");
   end
   if (PC_W < 1 || PC_W > BEAT_W) begin : g_bad_pcw
      $error("trace_sampler: PC_W must lie in 1..64");
   end

   base_cfg_t         base_q;
   trc_cfg_t          trc_q;
   logic [LOAD_W-1:0] load_nxt;
   logic              cfg_touch, off_clr;
   logic              sampling_en, trace_mode, active;
   logic              samp_fire, beat_last;
   logic [LOAD_W-1:0] samp_cnt;
   logic [TS_W-1:0]   ts_q;
   logic [EV_PAD-1:0] ev_pad;
   logic [SEL_W-1:0]  sel   [N_TALLY];
   logic [EV_W-1:0]   snap  [N_TALLY];
   logic [N_TALLY-1:0] ev_hit;

   ts_cfg_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_base (cfg_wr_base),
      .wr_trc  (cfg_wr_trace),
      .wdata   (cfg_wdata),
      .base_q  (base_q),
      .trc_q   (trc_q),
      .load_nxt(load_nxt),
      .touch   (cfg_touch),
      .clr_off (off_clr)
   );

   assign sampling_en = base_q.en;

   if (ACCUM_EN) begin : g_mode_sel
      assign trace_mode = base_q.trace;
   end else begin : g_mode_fixed
      logic unused_mode;
      assign unused_mode = base_q.trace;
      assign trace_mode  = 1'b1;
   end

   assign active = sampling_en & ~mem_valid & ~cfg_touch;

   ts_sample_ctr #(.W(LOAD_W)) u_samp (
      .clk   (clk),
      .rst_n (rst_n),
      .reload(cfg_touch),
      .step  (active),
      .load  (load_nxt),
      .fire  (samp_fire),
      .cnt_q (samp_cnt)
   );

   assign ev_pad = EV_PAD'(ev_in);
   assign sel[0] = trc_q.sel_a;
   assign sel[1] = trc_q.sel_b;

   for (genvar g = 0; g < N_TALLY; g++) begin : g_tally
      assign ev_hit[g] = ev_pad[sel[g]];
      ts_event_ctr #(.W(EV_W)) u_evc (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (cfg_touch | samp_fire),
         .step (active),
         .ev   (ev_hit[g]),
         .snap (snap[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ts_q <= '0;
      else        ts_q <= ts_q + 1'b1;
   end

   ts_record_emit u_emit (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (samp_fire),
      .trace_in (trace_mode),
      .base     (base_q.base),
      .code     (trc_q.code),
      .off_clr  (off_clr),
      .pc_w     (BEAT_W'(pc_in)),
      .cnt_a    (BEAT_W'(snap[0])),
      .cnt_b    (BEAT_W'(snap[1])),
      .ts_w     (BEAT_W'(ts_q)),
      .mem_ready(mem_ready),
      .mem_valid(mem_valid),
      .mem_addr (mem_addr),
      .mem_data (mem_data),
      .mem_add  (mem_add),
      .beat_last(beat_last)
   );
endmodule

// File: rtl/trace_sampler_chk.sv
module trace_sampler_chk
   import ts_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [BEAT_W-1:0] mem_data,
   input logic              mem_add,
   input logic              sampling_en,
   input logic              cfg_touch,
   input logic              samp_fire,
   input logic [LOAD_W-1:0] samp_cnt,
   input logic              beat_last
);
   assert_beat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                  && $stable(mem_data) && $stable(mem_add));

   assert_count_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !cfg_touch |=> $stable(samp_cnt));

   assert_idle_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !sampling_en && !mem_valid |=> !mem_valid);

   assert_rec_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      samp_fire |=> mem_valid && (mem_addr[4:0] == 5'd0));

   assert_beat_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr[2:0] == 3'd0));

   assert_rec_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready && beat_last |=> !mem_valid);

   assert_accum_words_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_add |-> !mem_addr[4]);
endmodule

bind trace_sampler trace_sampler_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_valid  (mem_valid),
   .mem_ready  (mem_ready),
   .mem_addr   (mem_addr),
   .mem_data   (mem_data),
   .mem_add    (mem_add),
   .sampling_en(sampling_en),
   .cfg_touch  (cfg_touch),
   .samp_fire  (samp_fire),
   .samp_cnt   (samp_cnt),
   .beat_last  (beat_last)
);

// File: tb/trace_sampler_tb_top.sv
module trace_sampler_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NEV        = 4;
   localparam int QD         = 16;
   localparam logic [55:0] BASE0 = 56'h12_3456_789A_C000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_base = 1'b0, cfg_wr_trace = 1'b0;
   logic [63:0] cfg_wdata = '0;
   logic [63:0] pc_in = '0;
   logic [NEV-1:0] ev_in = '0;
   logic        mem_ready = 1'b1;
   logic        mem_valid, mem_add;
   logic [55:0] mem_addr;
   logic [63:0] mem_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_sampler #(.NUM_EV(NEV)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_base(cfg_wr_base), .cfg_wr_trace(cfg_wr_trace),
      .cfg_wdata(cfg_wdata), .pc_in(pc_in), .ev_in(ev_in), .mem_valid(mem_valid),
      .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .mem_add(mem_add)
   );

   int n_vec = 0, n_bad = 0;
   bit done = 0;
   string tag = "";
   bit stall_on = 0;
   logic [15:0] lfsr = 16'hACE1;

   // reference state
   bit          m_en = 0, m_trace = 1;
   logic [55:0] m_base = '0;
   logic [31:0] m_load = '0;
   int          m_sa = 0, m_sb = 0, m_code = 0;
   longint      m_off = 0, m_per = 0, cyc = 0;
   logic [63:0] m_ca = '0, m_cb = '0;

   // expected beat queue
   logic [55:0] q_addr [QD];
   logic [63:0] q_data [QD];
   bit          q_add  [QD];
   bit          q_ts   [QD];
   longint      q_cyc  [QD];
   string       q_req  [QD];
   int          q_head = 0, q_tail = 0;
   bit          have_ts = 0;
   logic [63:0] last_ts = '0;
   longint      last_fire = 0;

   task automatic chk(string req, bit ok, logic [63:0] act, logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(logic [55:0] a, logic [63:0] d, bit add, bit is_ts, string req);
      q_addr[q_tail % QD] = a;  q_data[q_tail % QD] = d;
      q_add[q_tail % QD]  = add; q_ts[q_tail % QD]  = is_ts;
      q_cyc[q_tail % QD]  = cyc; q_req[q_tail % QD] = req;
      q_tail++;
   endtask

   function automatic logic [63:0] mk_base(bit en, bit tr, logic [55:0] a);
      return {en, tr, 2'b11, 3'b101, 1'b1, a[55:13], 13'h0F0F};
   endfunction

   function automatic logic [63:0] mk_trc(logic [31:0] ld, int sa, int sb, int code);
      return {2'b10, ld, 7'(sa), 7'(sb), 3'(code), 13'h1ABC};
   endfunction

   task automatic model_step();
      bit touch, ha, hb;
      int i;
      longint size, period;
      touch = cfg_wr_base | cfg_wr_trace;
      if (mem_valid && mem_ready) begin
         if (q_head == q_tail) chk({tag, " R12 R1 unexpected beat"}, 1'b0, 64'(mem_addr), 64'd0);
         else begin
            i = q_head % QD;
            chk({tag, " R2 R8 R11 ", q_req[i], " address"}, mem_addr == q_addr[i],
                64'(mem_addr), 64'(q_addr[i]));
            chk({tag, " R5 R9 ", q_req[i], " add flag"}, mem_add == q_add[i],
                64'(mem_add), 64'(q_add[i]));
            if (q_ts[i]) begin
               if (have_ts)
                  chk({tag, " R7 timestamp spacing"}, (mem_data - last_ts) == 64'(q_cyc[i] - last_fire),
                      mem_data - last_ts, 64'(q_cyc[i] - last_fire));
               have_ts = 1; last_ts = mem_data; last_fire = q_cyc[i];
            end else begin
               chk({tag, " ", q_req[i], " data"}, mem_data == q_data[i], mem_data, q_data[i]);
            end
            q_head++;
         end
      end
      if (m_en && !mem_valid && !touch) begin
         ha = (m_sa < NEV) ? ev_in[m_sa] : 1'b0;
         hb = (m_sb < NEV) ? ev_in[m_sb] : 1'b0;
         m_ca += 64'(ha); m_cb += 64'(hb);
         m_per++;
         period = 64'h1_0000_0000 - longint'(m_load);
         if (m_per == period) begin
            if (m_trace) begin
               push(m_base + 56'(m_off),      pc_in, 0, 0, "R4 R5 pc");
               push(m_base + 56'(m_off + 8),  m_ca,  0, 0, "R3 R6 tally A");
               push(m_base + 56'(m_off + 16), m_cb,  0, 0, "R3 R6 tally B");
               push(m_base + 56'(m_off + 24), 64'd0, 0, 1, "R7 ts");
               size = longint'(4096) << m_code;
               m_off = (m_off + 32) % size;
            end else begin
               push(m_base,     m_ca, 1, 0, "R9 accum A");
               push(m_base + 8, m_cb, 1, 0, "R9 accum B");
            end
            m_per = 0; m_ca = '0; m_cb = '0;
         end
      end
      if (touch) begin
         if (m_en) m_off = 0;
         m_per = 0; m_ca = '0; m_cb = '0;
         if (cfg_wr_base) begin
            m_en = cfg_wdata[63]; m_trace = cfg_wdata[62];
            m_base = {cfg_wdata[55:13], 13'd0};
         end
         if (cfg_wr_trace) begin
            m_load = cfg_wdata[61:30]; m_sa = int'(cfg_wdata[29:23]);
            m_sb = int'(cfg_wdata[22:16]); m_code = int'(cfg_wdata[15:13]);
         end
      end
      cyc++;
   endtask

   task automatic tick();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ev_in = lfsr[NEV-1:0];
      pc_in = 64'hA5A5_0000_0000_0000 ^ (64'(cyc) * 64'h9E37);
      mem_ready = stall_on ? (lfsr[7] | lfsr[9]) : 1'b1;
      model_step();
      @(negedge clk);
   endtask

   task automatic run(int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   task automatic wr(bit is_base, logic [63:0] d);
      cfg_wdata = d;
      cfg_wr_base = is_base; cfg_wr_trace = !is_base;
      tick();
      cfg_wr_base = 0; cfg_wr_trace = 0;
   endtask

   task automatic quiesce();
      wr(1'b1, mk_base(1'b0, 1'b1, BASE0));
      for (int k = 0; k < 200 && q_head != q_tail; k++) tick();
      chk({tag, " R5 every expected beat delivered"}, q_head == q_tail,
          64'(q_tail - q_head), 64'd0);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      chk("R1 no beat during reset", mem_valid == 1'b0, 64'(mem_valid), 64'd0);
      rst_n = 1'b1;
      tag = "R1";
      for (int k = 0; k < 10; k++) begin
         chk("R1 idle after reset", mem_valid == 1'b0, 64'(mem_valid), 64'd0);
         tick();
      end

      // sweep of periods and selects; each trace write while enabled restarts the buffer
      tag = "R11 sweep";
      wr(1'b0, mk_trc(32'hFFFF_FFFF, 0, 1, 0));
      wr(1'b1, mk_base(1'b1, 1'b1, BASE0));
      for (int per = 1; per <= 5; per++) begin
         for (int s = 0; s <= NEV; s++) begin
            wr(1'b0, mk_trc(32'(64'h1_0000_0000 - per), s, (s + 2) % (NEV + 1), 0));
            run(6 * (per + 4) + s);
         end
      end
      quiesce();

      // buffer wrap at two sizes, address arithmetic at the largest
      for (int code = 0; code <= 1; code++) begin
         tag = "R8 wrap";
         wr(1'b0, mk_trc(32'hFFFF_FFFF, 1, 3, code));
         wr(1'b1, mk_base(1'b1, 1'b1, BASE0));
         run(5 * ((4096 << code) / 32 + 12));
         quiesce();
      end
      tag = "R8 large";
      wr(1'b0, mk_trc(32'hFFFF_FFFE, 2, 0, 7));
      wr(1'b1, mk_base(1'b1, 1'b1, BASE0 + 56'h2000));
      run(150);
      quiesce();

      // back-pressure on the write port
      tag = "R10 stall";
      stall_on = 1;
      wr(1'b0, mk_trc(32'hFFFF_FFFD, 0, 3, 0));
      wr(1'b1, mk_base(1'b1, 1'b1, BASE0));
      run(600);
      quiesce();
      stall_on = 0;

      // accumulation mode
      tag = "R9 accum";
      wr(1'b0, mk_trc(32'hFFFF_FFFC, 3, 1, 0));
      wr(1'b1, mk_base(1'b1, 1'b0, BASE0));
      run(200);
      stall_on = 1;
      run(200);
      stall_on = 0;
      quiesce();

      // disabled: no records at all
      tag = "R12 disabled";
      wr(1'b0, mk_trc(32'hFFFF_FFFF, 0, 1, 0));
      for (int k = 0; k < 60; k++) begin
         chk("R12 no beat while disabled", mem_valid == 1'b0, 64'(mem_valid), 64'd0);
         tick();
      end

      // re-enable after idling: records restart at the base
      tag = "R11 restart";
      wr(1'b1, mk_base(1'b1, 1'b1, BASE0));
      run(100);
      quiesce();

      done = 1;
      summary();
      $finish;
   end
endmodule